// File: doc/BRIEF.md
# Set/Clear Interrupt Controller

This block gathers fourteen interrupt sources into a single three-bit priority level for a processor. It holds two sixteen-bit registers: an enable mask and a pending-request register. Software writes both through one shared data bus. The top bit of every write word picks the operation. Data bits that are 1 are either all set or all cleared, and data bits that are 0 leave their register bits untouched. This lets software change a single bit without a read-modify-write sequence.

Hardware sources raise their pending bits through single-cycle pulse inputs. The controller ANDs the pending bits with the enable mask. It gates the result with a master enable bit that lives only in the enable register. It then reports the highest level among the survivors. Each source has a fixed level from 1 to 6, and level 0 means that nothing is asserted. Both registers can be read back at all times. Vectoring and acknowledge cycles are handled elsewhere.

Top module: `intc_setclr_top`

## Requirements
- R1: A write with data bit 15 = 1 sets every register bit whose data bit is 1. Every bit whose data bit is 0 keeps its value.
- R2: A write with data bit 15 = 0 clears every register bit whose data bit is 1. Every bit whose data bit is 0 keeps its value.
- R3: Enable bit 14 is the master enable. While it is 0, `irq_level` is 0 whatever the pending and enable bits hold.
- R4: Source bit 13 maps to level 6, bits 12 and 11 to level 5, and bits 10 to 7 to level 4. Bits 6 to 4 map to level 3, bit 3 to level 2, and bits 2 to 0 to level 1.
- R5: `irq_level` is the highest level among the sources that are both pending and enabled while the master enable is 1. It is 0 when no such source exists. It follows a register change in the same cycle as that change.
- R6: A pulse on `src_pulse[i]` sets pending bit i on the next clock edge. This holds even when a clear write to bit i lands in the same cycle.
- R7: Bit 15 of both read ports is always 0. Bit 14 of the pending read port is always 0, even after a set write with data bit 14 = 1.
- R8: After reset, both registers read 0 and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | Write strobe for the enable register |
| pend_wr | input | 1 | Write strobe for the pending register |
| wr_data | input | 16 | Write word; bit 15 selects set (1) or clear (0) |
| src_pulse | input | 14 | Hardware set pulses, one per source |
| mask_rd | output | 16 | Enable register read-back |
| pend_rd | output | 16 | Pending register read-back |
| irq_level | output | 3 | Highest active priority level, 0 if none |

## Verification
The bench builds the block with its default sizes: fourteen sources, sixteen-bit registers and three level bits. That configuration is small enough to sweep completely. Every source is checked alone against its level, and every pair of sources is checked against the higher of their two levels. A long pseudo-random run of mixed set and clear writes to both registers, with overlapping hardware pulses, is compared against an arithmetic model. The run includes same-cycle collisions between a clear write and a pulse, and attempts to write the reserved bits.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int DATA_W     = 16;
    localparam int NUM_SRC    = 14;
    localparam int LVL_W      = 3;
    localparam int OP_BIT     = DATA_W - 1;
    localparam int MASTER_BIT = DATA_W - 2;
    localparam int NUM_LVL    = 1 << LVL_W;

    // Fixed source to priority level mapping
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        if (idx >= 13)      return LVL_W'(6);
        else if (idx >= 11) return LVL_W'(5);
        else if (idx >= 7)  return LVL_W'(4);
        else if (idx >= 4)  return LVL_W'(3);
        else if (idx == 3)  return LVL_W'(2);
        else                return LVL_W'(1);
    endfunction

    // Mask of sources belonging to one level
    function automatic logic [NUM_SRC-1:0] level_mask(input int lvl);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(src_level(i)) == lvl) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/intc_sc_reg.sv
module intc_sc_reg #(
    parameter int              W        = 16,
    parameter int              HW_W     = 14,
    parameter logic [W-1:0]    IMPL     = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [W-1:0]    wdata,
    input  logic [HW_W-1:0] hw_set,
    output logic [W-1:0]    q
);
    localparam int OPB = W - 1;

    typedef struct packed {
        logic [W-1:0] bits;
    } state_t;

    state_t st_d, st_q;
    logic [W-1:0] hw_ext;
    logic [W-1:0] sel;

    always_comb begin
        hw_ext = '0;
        hw_ext[HW_W-1:0] = hw_set;
        sel  = wdata & IMPL;
        st_d = st_q;
        if (wr) begin
            if (wdata[OPB]) st_d.bits = st_q.bits | sel;
            else            st_d.bits = st_q.bits & ~sel;
        end
        // hardware set applied last: it overrides a same-cycle clear
        st_d.bits = st_d.bits | (hw_ext & IMPL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;

    // R1: set write raises every selected implemented bit
    a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[OPB]) |=> ((q & $past(wdata & IMPL)) == $past(wdata & IMPL)));
    // R1/R2: bits written as zero stay unchanged when no hardware pulse arrives
    a_r1_zero_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hw_set == '0) |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
    // R2: clear write drops selected bits not raised by hardware
    a_r2_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[OPB]) |=> ((q & $past(wdata & ~hw_ext)) == '0));
    // R6: hardware pulse always lands
    a_r6_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> ((q & $past(hw_ext & IMPL)) == $past(hw_ext & IMPL)));
    // R7: unimplemented bits never become 1
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~IMPL) == '0);
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active,
    input  logic               master,
    output logic [LVL_W-1:0]   level
);
    logic [NUM_LVL-1:0] lvl_hit;

    assign lvl_hit[0] = 1'b0;
    for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
        localparam logic [NUM_SRC-1:0] LMASK = level_mask(l);
        assign lvl_hit[l] = master && ((active & LMASK) != '0);
    end

    always_comb begin
        level = '0;
        for (int l = 1; l < NUM_LVL; l++) begin
            if (lvl_hit[l]) level = LVL_W'(l);
        end
    end

    // R3: no level without the master enable
    a_r3_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> level == '0);
    // R5: nothing active means level 0
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> level == '0);
    // R5: something active under master gives nonzero level
    a_r5_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (master && active != '0) |-> level != '0);
    // R4: top source dominates at level 6
    a_r4_top_source: assert property (@(posedge clk) disable iff (!rst_n)
        (master && active[NUM_SRC-1]) |-> level == LVL_W'(6));
endmodule

// File: rtl/intc_setclr_top.sv
module intc_setclr_top
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr,
    input  logic               pend_wr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic [DATA_W-1:0]  mask_rd,
    output logic [DATA_W-1:0]  pend_rd,
    output logic [LVL_W-1:0]   irq_level
);
    localparam logic [DATA_W-1:0] SRC_BITS  = DATA_W'((1 << NUM_SRC) - 1);
    localparam logic [DATA_W-1:0] MASK_IMPL = SRC_BITS | (DATA_W'(1) << MASTER_BIT);
    localparam logic [DATA_W-1:0] PEND_IMPL = SRC_BITS;

    logic [DATA_W-1:0] mask_q, pend_q;
    logic [NUM_SRC-1:0] active;

    intc_sc_reg #(.W(DATA_W), .HW_W(NUM_SRC), .IMPL(MASK_IMPL)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(wr_data),
        .hw_set('0), .q(mask_q)
    );

    intc_sc_reg #(.W(DATA_W), .HW_W(NUM_SRC), .IMPL(PEND_IMPL)) u_pend (
        .clk(clk), .rst_n(rst_n), .wr(pend_wr), .wdata(wr_data),
        .hw_set(src_pulse), .q(pend_q)
    );

    assign active = pend_q[NUM_SRC-1:0] & mask_q[NUM_SRC-1:0];

    intc_prio u_prio (
        .clk(clk), .rst_n(rst_n), .active(active),
        .master(mask_q[MASTER_BIT]), .level(irq_level)
    );

    assign mask_rd = mask_q;
    assign pend_rd = pend_q;

    // R7: operation bit never reads back, pending bit 14 never reads back
    a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_rd[OP_BIT] && !pend_rd[OP_BIT] && !pend_rd[MASTER_BIT]);
endmodule

// File: tb/sim_intc_setclr_top.sv
module sim_intc_setclr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mask_wr = 1'b0;
    logic        pend_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [13:0] src_pulse = '0;
    logic [15:0] mask_rd, pend_rd;
    logic [2:0]  irq_level;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_mask = '0;
    logic [15:0] m_pend = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    intc_setclr_top u0 (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .pend_wr(pend_wr),
        .wr_data(wr_data), .src_pulse(src_pulse),
        .mask_rd(mask_rd), .pend_rd(pend_rd), .irq_level(irq_level)
    );

    function automatic int lvl_of(input int i);
        if (i == 13) return 6;
        if (i >= 11) return 5;
        if (i >= 7)  return 4;
        if (i >= 4)  return 3;
        if (i == 3)  return 2;
        return 1;
    endfunction

    function automatic int exp_level(input logic [15:0] m, input logic [15:0] p);
        int best;
        best = 0;
        if (!m[14]) return 0;
        for (int i = 0; i < 14; i++)
            if (m[i] && p[i] && lvl_of(i) > best) best = lvl_of(i);
        return best;
    endfunction

    function automatic logic [15:0] apply(input logic [15:0] cur, input logic [15:0] d,
                                          input logic [15:0] impl);
        if (d[15]) return cur | (d & impl);
        return cur & ~(d & impl);
    endfunction

    task automatic check(input string req);
        int el;
        el = exp_level(m_mask, m_pend);
        checks++;
        if (mask_rd !== m_mask || pend_rd !== m_pend || int'(irq_level) != el) begin
            errors++;
            $display("FAIL %s: mask=%h pend=%h lvl=%0d expected mask=%h pend=%h lvl=%0d",
                     req, mask_rd, pend_rd, irq_level, m_mask, m_pend, el);
        end
    endtask

    // one bus cycle: drive at negedge, clock, return at next negedge
    task automatic cyc(input logic mw, input logic pw, input logic [15:0] d,
                       input logic [13:0] hw);
        mask_wr = mw; pend_wr = pw; wr_data = d; src_pulse = hw;
        if (mw) m_mask = apply(m_mask, d, 16'h7FFF);
        if (pw) m_pend = apply(m_pend, d, 16'h3FFF);
        m_pend = m_pend | {2'b00, hw};
        @(posedge clk);
        @(negedge clk);
        mask_wr = 0; pend_wr = 0; wr_data = '0; src_pulse = '0;
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R8 reset state");

        // R1: enable everything, bit 15 reads 0 (R7)
        cyc(1, 0, 16'hFFFF, '0);
        check("R1 set all enables / R7 op bit");

        // R4: each source alone
        for (int i = 0; i < 14; i++) begin
            cyc(0, 0, '0, 14'(1 << i));
            check($sformatf("R4 source %0d level", i));
            cyc(0, 1, 16'(1 << i), '0);
            check("R2 clear single pending / R5 zero");
        end

        // R3: master off blocks everything
        cyc(1, 0, 16'h4000, '0);
        cyc(0, 0, '0, 14'h3FFF);
        check("R3 master off gives level 0");
        cyc(0, 1, 16'hC000, '0);
        check("R7 pending bit 14 reads 0");
        cyc(1, 0, 16'hC000, '0);
        check("R3 master on restores level");

        // R5: every pair of sources via software set
        for (int i = 0; i < 14; i++) begin
            for (int j = 0; j < 14; j++) begin
                cyc(0, 1, 16'h7FFF, '0);
                cyc(0, 1, 16'h8000 | 16'(1 << i) | 16'(1 << j), '0);
                check($sformatf("R5 pair %0d,%0d", i, j));
            end
        end

        // R5: masked source does not count
        cyc(0, 1, 16'h7FFF, '0);
        cyc(0, 1, 16'hA008, '0);
        cyc(1, 0, 16'h2000, '0);
        check("R5 disabled source ignored");
        cyc(1, 0, 16'hA000, '0);

        // R6: pulse collides with clear write
        cyc(0, 1, 16'h8060, '0);
        cyc(0, 1, 16'h0060, 14'h0020);
        check("R6 pulse beats clear");

        // R1/R2: pseudo-random mix
        for (int k = 0; k < 2000; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3], lfsr[7], lfsr[31:16],
                lfsr[11] ? 14'(lfsr[29:16] & lfsr[13:0]) : 14'h0);
            check(lfsr[31] ? "R1 random set write" : "R2 random clear write");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule